// File: doc/BRIEF.md
# Square Wave Carrier Generator

This block drives one output pin with a continuous square wave whose timing comes from a slow, fixed-rate tick enable rather than from the system clock rate. The tick is meant to be a 1 MHz pulse, for example a 40 MHz crystal clock divided by 40, or a ready-made 1 MHz reference tick. Every tick advances a phase counter. The carrier high and low phases each last a programmable number of ticks. With both set to one tick, a 1 MHz tick gives a 500 kHz wave at 50 % duty, which a downstream edge counter can use as a timebase that does not move when bus or processor clocks are retuned.

Software sets the block up through a small write port. The settings are the two phase lengths, one data item (its level and its length in ticks), the level at which the carrier is applied, the idle level and two flags: the modulation enable and the always-on flag. A start strobe launches the item. While the item's level matches the carrier level, the pin carries the square wave. Otherwise the pin holds the item level. When the item runs out, the pin returns to the idle level, unless always-on is set, in which case the wave continues with no end. Clearing the modulation enable stops the output at once.

Register map (2-bit address, data `CNT_W` bits wide): address 0 is control, address 1 is the high-phase length, address 2 is the low-phase length, and address 3 is the item length. The control bits are: bit 0 modulation enable, bit 1 always-on, bit 2 carrier level, bit 3 idle level, bit 4 item level.

Top module: `sqw_carrier_gen`

## Requirements
- R1: After reset the control register is all zero, every length register holds 1, the block is stopped and `wave_out` is 0.
- R2: While stopped, `wave_out` equals the idle level (control bit 3) from the clock edge that writes it.
- R3: A start strobe with modulation enabled begins a high carrier phase of the full programmed high length, measured in ticks. A start in the same cycle as a tick takes priority over that tick.
- R4: While running, the carrier alternates high phases of the high length and low phases of the low length, changing only at the clock edge that takes the last tick of a phase.
- R5: Writing 0 to any length register (addresses 1 to 3) stores 1.
- R6: While the item level differs from the carrier level, `wave_out` holds the item level and does not toggle.
- R7: With always-on clear, the item lasts exactly the item-length number of ticks, and `wave_out` then returns to the idle level.
- R8: With always-on set (control bit 1), the wave keeps toggling after the item length has elapsed.
- R9: Writing control with bit 0 clear stops the block at that write's edge, so `wave_out` shows the idle level. A start strobe is ignored while modulation is disabled.
- R10: A new high or low length written mid-phase does not shorten or lengthen the phase in progress. It applies from the next reload.
- R11: A start strobe while running restarts the pattern with a full-length high phase.
- R12: Without tick pulses the phase and the output do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1us | input | 1 | One-cycle tick enable from the fixed reference (nominally 1 MHz) |
| start | input | 1 | Start strobe, one cycle |
| cfg_wr | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address: 0 control, 1 high length, 2 low length, 3 item length |
| cfg_wdata | input | CNT_W | Register write data |
| wave_out | output | 1 | Modulated output to the pin |

## Verification
All state, the configuration included, sits in registers that the output decodes directly. A write, a start or a tick presented in one cycle therefore shows on `wave_out` right after the next rising edge, and never later. The bench drives inputs on the falling edge and keeps a behavioural model, updated on the rising edge, that is compared with `wave_out` on every falling edge, so each result is checked in the cycle it becomes due. Phase and item lengths are measured by counting the ticks presented while the output holds one level. A length of N therefore reads back as exactly N ticks, whatever the spacing of the ticks.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

  // Control word layout; bit 0 is the lowest field.
  typedef struct packed {
    logic item_lvl;   // bit 4
    logic idle_lvl;   // bit 3
    logic car_lvl;    // bit 2
    logic always_on;  // bit 1
    logic mod_en;     // bit 0
  } sqw_ctrl_t;

  localparam int CTRL_W = $bits(sqw_ctrl_t);

  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_HIGH = 2'd1,
    ADR_LOW  = 2'd2,
    ADR_ITEM = 2'd3
  } sqw_addr_e;

  // Pin level from run state, carrier phase and control.
  function automatic logic sqw_pin_level(input logic running,
                                         input logic phase_hi,
                                         input sqw_ctrl_t c);
    if (!running)
      return c.idle_lvl;
    if (c.item_lvl == c.car_lvl)
      return phase_hi;
    return c.item_lvl;
  endfunction

endpackage

// File: rtl/sqw_cfg_regs.sv
module sqw_cfg_regs
  import sqw_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output sqw_ctrl_t        ctrl_q,
  output sqw_ctrl_t        ctrl_nxt,
  output logic [CNT_W-1:0] hi_nxt,
  output logic [CNT_W-1:0] lo_nxt,
  output logic [CNT_W-1:0] len_nxt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] hi_q, lo_q, len_q;

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  always_comb begin
    ctrl_nxt = ctrl_q;
    hi_nxt   = hi_q;
    lo_nxt   = lo_q;
    len_nxt  = len_q;
    if (wr_en) begin
      case (wr_addr)
        ADR_CTRL: ctrl_nxt = sqw_ctrl_t'(wr_data[CTRL_W-1:0]);
        ADR_HIGH: hi_nxt   = at_least_one(wr_data);
        ADR_LOW:  lo_nxt   = at_least_one(wr_data);
        default:  len_nxt  = at_least_one(wr_data);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      hi_q   <= ONE;
      lo_q   <= ONE;
      len_q  <= ONE;
    end else begin
      ctrl_q <= ctrl_nxt;
      hi_q   <= hi_nxt;
      lo_q   <= lo_nxt;
      len_q  <= len_nxt;
    end
  end

  // R5: a length register never holds zero after a write
  a_r5_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != ADR_CTRL) |=> (hi_q != '0 && lo_q != '0 && len_q != '0));

endmodule

// File: rtl/sqw_phase_timer.sv
module sqw_phase_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  input  logic [CNT_W-1:0] hi_len,
  input  logic [CNT_W-1:0] lo_len,
  output logic             phase_hi,
  output logic             phase_wrap
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             ph_q;

  // Length of the phase that follows the current one.
  function automatic logic [CNT_W-1:0] next_len(input logic now_hi,
                                                input logic [CNT_W-1:0] h,
                                                input logic [CNT_W-1:0] l);
    return now_hi ? l : h;
  endfunction

  assign phase_wrap = advance && (cnt_q <= ONE);
  assign phase_hi   = ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      cnt_q <= '0;
    end else if (restart) begin
      ph_q  <= 1'b1;
      cnt_q <= hi_len;
    end else if (advance) begin
      if (phase_wrap) begin
        ph_q  <= ~ph_q;
        cnt_q <= next_len(ph_q, hi_len, lo_len);
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  // R3: a restart always opens a high phase with a loaded count
  a_r3_restart_high: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ph_q && cnt_q != '0));

  // R12: the phase holds when neither restart nor advance occurs
  a_r12_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !advance) |=> $stable(ph_q));

  // R4: the phase flips only on a wrap event
  a_r4_flip_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !phase_wrap) |=> $stable(ph_q));

endmodule

// File: rtl/sqw_item_timer.sv
module sqw_item_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_eff,
  input  logic             always_eff,
  input  logic             start,
  input  logic             tick,
  input  logic [CNT_W-1:0] len_eff,
  output logic             running,
  output logic             restart,
  output logic             advance,
  output logic             item_end
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] left_q;
  logic             run_q;

  assign restart  = en_eff && start;
  assign advance  = en_eff && !start && run_q && tick;
  assign item_end = advance && (left_q <= ONE);
  assign running  = run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      left_q <= '0;
    end else if (!en_eff) begin
      run_q  <= 1'b0;
    end else if (start) begin
      run_q  <= 1'b1;
      left_q <= len_eff;
    end else if (advance) begin
      if (item_end) begin
        left_q <= '0;
        if (!always_eff)
          run_q <= 1'b0;
      end else begin
        left_q <= left_q - ONE;
      end
    end
  end

  // R7: the item ending without always-on stops the block
  a_r7_stop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (item_end && !always_eff) |=> !run_q);

  // R8: with always-on the block keeps running past the item end
  a_r8_keep_running: assert property (@(posedge clk) disable iff (!rst_n)
    (item_end && always_eff && en_eff) |=> run_q);

  // R9: disabled modulation leaves the block stopped, start or not
  a_r9_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !en_eff |=> !run_q);

endmodule

// File: rtl/sqw_carrier_gen.sv
module sqw_carrier_gen
  import sqw_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1us,
  input  logic             start,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  output logic             wave_out
);

  sqw_ctrl_t        ctrl_q, ctrl_nxt;
  logic [CNT_W-1:0] hi_nxt, lo_nxt, len_nxt;
  logic             running, restart, advance, item_end;
  logic             phase_hi, phase_wrap;

  sqw_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_wdata),
    .ctrl_q   (ctrl_q),
    .ctrl_nxt (ctrl_nxt),
    .hi_nxt   (hi_nxt),
    .lo_nxt   (lo_nxt),
    .len_nxt  (len_nxt)
  );

  sqw_item_timer #(.CNT_W(CNT_W)) u_item (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_eff     (ctrl_nxt.mod_en),
    .always_eff (ctrl_nxt.always_on),
    .start      (start),
    .tick       (tick_1us),
    .len_eff    (len_nxt),
    .running    (running),
    .restart    (restart),
    .advance    (advance),
    .item_end   (item_end)
  );

  sqw_phase_timer #(.CNT_W(CNT_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .advance    (advance),
    .hi_len     (hi_nxt),
    .lo_len     (lo_nxt),
    .phase_hi   (phase_hi),
    .phase_wrap (phase_wrap)
  );

  assign wave_out = sqw_pin_level(running, phase_hi, ctrl_q);

  // R6: mismatched item and carrier levels give a steady pin
  a_r6_steady_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !$past(start) && $stable(ctrl_q)
     && ctrl_q.item_lvl != ctrl_q.car_lvl) |-> $stable(wave_out));

  // R12: with no tick or start the running pin does not move
  a_r12_pin_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !$past(tick_1us) && !$past(start)
     && $stable(ctrl_q)) |-> $stable(wave_out));

  // R9: clearing the enable shows the idle level on the next cycle
  a_r9_idle_after_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == ADR_CTRL && !cfg_wdata[0]) |=> (wave_out == $past(cfg_wdata[3])));

  // R4: a wrap with matching levels toggles the pin
  a_r4_wrap_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_wrap && !item_end && !cfg_wr && ctrl_q.item_lvl == ctrl_q.car_lvl)
      |=> (wave_out != $past(wave_out)));

endmodule

// File: tb/sqw_carrier_gen_tb.sv
module sqw_carrier_gen_tb;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          start = 1'b0;
  logic          wr = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [CW-1:0] wdata = '0;
  logic          wave;

  int    checks = 0;
  int    fails = 0;
  string cur_req = "R1";
  int    tcnt = 0;
  bit    model_on = 1'b0;
  bit    done = 1'b0;

  always #4 clk = ~clk;

  sqw_carrier_gen #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick), .start(start),
    .cfg_wr(wr), .cfg_addr(addr), .cfg_wdata(wdata), .wave_out(wave)
  );

  // Behavioural reference, plain integers.
  int m_en, m_alw, m_car, m_idle, m_ilvl;
  int m_hi, m_lo, m_len;
  int m_act, m_ph, m_cnt, m_left;
  int m_wave;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_alw = 0; m_car = 0; m_idle = 0; m_ilvl = 0;
      m_hi = 1; m_lo = 1; m_len = 1;
      m_act = 0; m_ph = 0; m_cnt = 0; m_left = 0;
    end else begin
      if (wr) begin
        if (addr == 2'd0) begin
          m_en = wdata[0]; m_alw = wdata[1]; m_car = wdata[2];
          m_idle = wdata[3]; m_ilvl = wdata[4];
        end else if (addr == 2'd1) m_hi = (wdata == 0) ? 1 : int'(wdata);
        else if (addr == 2'd2) m_lo = (wdata == 0) ? 1 : int'(wdata);
        else m_len = (wdata == 0) ? 1 : int'(wdata);
      end
      if (m_en == 0) m_act = 0;
      else if (start) begin
        m_act = 1; m_ph = 1; m_cnt = m_hi; m_left = m_len;
      end else if (m_act == 1 && tick) begin
        if (m_cnt <= 1) begin
          m_ph = 1 - m_ph;
          m_cnt = (m_ph == 1) ? m_hi : m_lo;
        end else m_cnt = m_cnt - 1;
        if (m_left <= 1) begin
          m_left = 0;
          if (m_alw == 0) m_act = 0;
        end else m_left = m_left - 1;
      end
    end
    if (m_act == 0) m_wave = m_idle;
    else if (m_ilvl == m_car) m_wave = m_ph;
    else m_wave = m_ilvl;
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      checks++;
      if (wave !== m_wave[0]) begin
        fails++;
        $display("FAIL %s per-cycle compare: actual=%0b expected=%0b", cur_req, wave, m_wave[0]);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus, driven on the falling edge.
  task automatic step(input bit w, input logic [1:0] a, input int d,
                      input bit s, input bit t);
    @(negedge clk);
    wr = w; addr = a; wdata = d[CW-1:0]; start = s;
    tick = t && (tcnt == 3);
    if (t) tcnt = (tcnt + 1) % 4;
  endtask

  task automatic wreg(input logic [1:0] a, input int d);
    step(1'b1, a, d, 1'b0, 1'b0);
  endtask

  // Count ticks presented while the pin stays at lvl.
  task automatic measure(input logic lvl, output int n);
    n = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wr = 1'b0; start = 1'b0;
      if (wave !== lvl) begin
        tick = 1'b0;
        break;
      end
      tick = (tcnt == 3);
      tcnt = (tcnt + 1) % 4;
      if (tick) n++;
    end
  endtask

  function automatic int ctrl(input bit en, input bit alw, input bit car,
                              input bit idle, input bit ilvl);
    return int'(en) | (int'(alw) << 1) | (int'(car) << 2) |
           (int'(idle) << 3) | (int'(ilvl) << 4);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL all watchdog expired: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    bit ok;
    int toggles;
    logic last;

    repeat (3) step(1'b0, 2'd0, 0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    model_on = 1'b1;
    step(1'b0, 2'd0, 0, 1'b0, 1'b0);
    // R1: reset state
    check(wave === 1'b0, "R1", "output after reset", wave, 0);

    // R2: idle level shown while stopped
    cur_req = "R2";
    wreg(2'd0, ctrl(0, 0, 0, 1, 0));
    step(1'b0, 2'd0, 0, 1'b0, 1'b0);
    check(wave === 1'b1, "R2", "idle level while stopped", wave, 1);

    // R9: start ignored while disabled
    cur_req = "R9";
    step(1'b0, 2'd0, 0, 1'b1, 1'b1);
    repeat (5) step(1'b0, 2'd0, 0, 1'b0, 1'b1);
    check(wave === 1'b1, "R9", "start ignored when disabled", wave, 1);

    // R3/R4: phase lengths 3 high, 5 low
    cur_req = "R3";
    wreg(2'd1, 3);
    wreg(2'd2, 5);
    wreg(2'd3, 200);
    wreg(2'd0, ctrl(1, 0, 1, 1, 1));
    step(1'b0, 2'd0, 0, 1'b1, 1'b0);
    measure(1'b1, n);
    check(n == 3, "R3", "first high phase ticks", n, 3);
    cur_req = "R4";
    measure(1'b0, n);
    check(n == 5, "R4", "low phase ticks", n, 5);
    measure(1'b1, n);
    check(n == 3, "R4", "second high phase ticks", n, 3);

    // R5: zero lengths become 1
    cur_req = "R5";
    wreg(2'd1, 0);
    wreg(2'd2, 0);
    step(1'b0, 2'd0, 0, 1'b1, 1'b0);
    measure(1'b1, n);
    check(n == 1, "R5", "high length after writing 0", n, 1);
    measure(1'b0, n);
    check(n == 1, "R5", "low length after writing 0", n, 1);

    // R10: length change mid-phase applies at next reload
    cur_req = "R10";
    wreg(2'd1, 4);
    wreg(2'd2, 4);
    step(1'b0, 2'd0, 0, 1'b1, 1'b0);
    wreg(2'd1, 2);
    measure(1'b1, n);
    check(n == 4, "R10", "phase in progress keeps old length", n, 4);
    measure(1'b0, n);
    check(n == 4, "R10", "low phase", n, 4);
    measure(1'b1, n);
    check(n == 2, "R10", "next high phase uses new length", n, 2);

    // R11: restart mid-phase gives a full high phase
    cur_req = "R11";
    wreg(2'd1, 3);
    step(1'b0, 2'd0, 0, 1'b1, 1'b0);
    tcnt = 0;
    repeat (4) step(1'b0, 2'd0, 0, 1'b0, 1'b1);
    step(1'b0, 2'd0, 0, 1'b1, 1'b0);
    measure(1'b1, n);
    check(n == 3, "R11", "high phase after restart", n, 3);

    // R6: item level differs from carrier level -> steady item level
    cur_req = "R6";
    wreg(2'd0, ctrl(1, 0, 1, 1, 0));
    step(1'b0, 2'd0, 0, 1'b1, 1'b0);
    ok = 1'b1;
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 2'd0, 0, 1'b0, 1'b1);
      if (wave !== 1'b0) ok = 1'b0;
    end
    check(ok, "R6", "steady item level on mismatch", ok, 1);

    // R7: item of 6 ticks, then idle
    cur_req = "R7";
    wreg(2'd1, 1);
    wreg(2'd2, 1);
    wreg(2'd3, 6);
    wreg(2'd0, ctrl(1, 0, 0, 0, 1));
    step(1'b0, 2'd0, 0, 1'b1, 1'b0);
    measure(1'b1, n);
    check(n == 6, "R7", "item length in ticks", n, 6);
    repeat (20) step(1'b0, 2'd0, 0, 1'b0, 1'b1);
    check(wave === 1'b0, "R7", "idle after item end", wave, 0);

    // R8: always-on keeps the wave going past a 2-tick item
    cur_req = "R8";
    wreg(2'd3, 2);
    wreg(2'd0, ctrl(1, 1, 1, 0, 1));
    step(1'b0, 2'd0, 0, 1'b1, 1'b0);
    toggles = 0;
    last = wave;
    for (int i = 0; i < 80; i++) begin
      step(1'b0, 2'd0, 0, 1'b0, 1'b1);
      if (wave !== last) toggles++;
      last = wave;
    end
    check(toggles >= 15, "R8", "toggles after item end", toggles, 15);

    // R9: clearing the enable stops the wave at once
    cur_req = "R9";
    wreg(2'd0, ctrl(0, 1, 1, 1, 1));
    step(1'b0, 2'd0, 0, 1'b0, 1'b1);
    check(wave === 1'b1, "R9", "idle right after disable", wave, 1);
    ok = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step(1'b0, 2'd0, 0, 1'b0, 1'b1);
      if (wave !== 1'b1) ok = 1'b0;
    end
    check(ok, "R9", "stays idle while disabled", ok, 1);

    // R12: no ticks, no change
    cur_req = "R12";
    wreg(2'd3, 5);
    wreg(2'd0, ctrl(1, 0, 1, 0, 1));
    step(1'b0, 2'd0, 0, 1'b1, 1'b0);
    ok = 1'b1;
    for (int i = 0; i < 30; i++) begin
      step(1'b0, 2'd0, 0, 1'b0, 1'b0);
      if (wave !== 1'b1) ok = 1'b0;
    end
    check(ok, "R12", "high held without ticks", ok, 1);
    measure(1'b1, n);
    check(n == 1, "R12", "phase ends on first tick", n, 1);

    repeat (2) step(1'b0, 2'd0, 0, 1'b0, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule